// File: doc/BRIEF.md
# Translation Lookaside Buffer with Access Protection

This block keeps a small, fully associative set of recent address translations. A lookup presents a virtual address with its access kind (read or write) and the privilege of the requester (kernel or user). In the same cycle the block returns the physical address, a hit or miss indication, and two fault flags. The first flag marks an access the entry does not permit. The second marks a permitted write to a page that is not yet marked modified.

Each entry maps either a 4 KB page or a 4 MB page. On a large page, the lower ten bits of the virtual page number are left out of the tag compare and are carried straight into the physical address. A miss raises a request to an external page-table walker. The walker answers later with a refill entry, which the block installs in a free slot if one exists and otherwise in the slot chosen by a round-robin pointer. A flush input invalidates every entry in one cycle.

Top module: `tlb_prot`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses, and the replacement pointer is at entry 0.
- R2: A lookup that matches a small-page entry raises hit in the same cycle, with miss low, and paddr equal to the entry's 20-bit PPN joined above vaddr[11:0].
- R3: A large-page entry matches on vaddr[31:22] alone, and paddr is the entry's PPN bits [19:10] joined above vaddr[21:0].
- R4: A lookup that matches no valid entry raises miss and walk_req, with walk_vpn equal to vaddr[31:12], and hit, both faults and paddr all low. With req_valid low, hit, miss, walk_req, both faults, walk_vpn and paddr are all 0.
- R5: On a hit, a read to an entry with its read-enable bit clear, or a write to an entry with its write-enable bit clear, raises prot_fault.
- R6: On a hit, a user access (req_user=1) to an entry marked kernel-only raises prot_fault even when the needed permission bit is set. A kernel access is not refused for this reason.
- R7: A write hit without prot_fault to an entry whose dirty bit is clear raises dirty_fault. dirty_fault is never high together with prot_fault.
- R8: A refill is written into the lowest-numbered invalid entry when one exists.
- R9: When all entries are valid, a refill overwrites the entry at the round-robin pointer. The pointer advances by one, modulo the entry count, on every accepted refill.
- R10: flush clears every valid bit in one cycle. A refill in the same cycle as flush is dropped and does not move the pointer.
- R11: A lookup in the same cycle as a refill sees the contents before the refill. The new entry is visible from the next cycle.
- R12: When several valid entries match, the lowest-numbered one supplies the translation and the permissions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual address of the lookup |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user mode, 0 = kernel mode |
| refill_valid | input | 1 | Install a new entry |
| refill_vpn | input | 20 | Tag of the new entry |
| refill_ppn | input | 20 | Physical page number of the new entry |
| refill_rd | input | 1 | Read permitted |
| refill_wr | input | 1 | Write permitted |
| refill_dirty | input | 1 | Page already modified |
| refill_kern | input | 1 | Kernel-only page |
| refill_large | input | 1 | Entry maps a 4 MB page |
| paddr | output | 32 | Translated physical address (0 unless hit) |
| hit | output | 1 | Lookup matched a valid entry |
| miss | output | 1 | Lookup matched nothing |
| prot_fault | output | 1 | Access refused by permission or privilege |
| dirty_fault | output | 1 | Write to an unmodified page |
| walk_req | output | 1 | Request to the page-table walker |
| walk_vpn | output | 20 | Page number to walk (0 unless walk_req) |

## Verification
The two actions that can land in the same cycle are a lookup and a refill, and a refill and a flush. The bench runs a lookup of a page while that same page's refill is being presented, and expects a miss in that cycle and a hit in the next. It also presents a refill together with flush and expects both the old and the new page to miss afterwards. After that it fills every slot so that the next replacement shows whether the pointer moved during the dropped refill. A random phase mixes both pairs freely, and a bench model applies flush before refill and reads the contents from before the edge.

// File: rtl/tlb_prot.sv
module tlb_prot #(
  parameter int N_ENT   = 16,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int PG_BITS = 12,
  parameter int LG_BITS = 22
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic                    req_valid,
  input  logic [VA_W-1:0]         req_vaddr,
  input  logic                    req_write,
  input  logic                    req_user,
  input  logic                    refill_valid,
  input  logic [VA_W-PG_BITS-1:0] refill_vpn,
  input  logic [PA_W-PG_BITS-1:0] refill_ppn,
  input  logic                    refill_rd,
  input  logic                    refill_wr,
  input  logic                    refill_dirty,
  input  logic                    refill_kern,
  input  logic                    refill_large,
  output logic [PA_W-1:0]         paddr,
  output logic                    hit,
  output logic                    miss,
  output logic                    prot_fault,
  output logic                    dirty_fault,
  output logic                    walk_req,
  output logic [VA_W-PG_BITS-1:0] walk_vpn
);
  localparam int VPN_W = VA_W - PG_BITS;
  localparam int PPN_W = PA_W - PG_BITS;
  localparam int SUB_W = LG_BITS - PG_BITS;
  localparam int IDX_W = $clog2(N_ENT);

  logic [N_ENT-1:0] v_q, r_q, w_q, d_q, k_q, l_q;
  logic [VPN_W-1:0] tag_q [N_ENT];
  logic [PPN_W-1:0] ppn_q [N_ENT];
  logic [IDX_W-1:0] rr_q;

  wire [VPN_W-1:0] vpn = req_vaddr[VA_W-1:PG_BITS];

  logic [N_ENT-1:0] match;
  genvar gi;
  generate
    for (gi = 0; gi < N_ENT; gi++) begin : g_cmp
      wire hi_eq = tag_q[gi][VPN_W-1:SUB_W] == vpn[VPN_W-1:SUB_W];
      wire lo_eq = tag_q[gi][SUB_W-1:0] == vpn[SUB_W-1:0];
      assign match[gi] = v_q[gi] && hi_eq && (l_q[gi] || lo_eq);
    end
  endgenerate

  logic [IDX_W-1:0] sel, free_idx;
  logic             any_match, any_free;
  always_comb begin
    sel = '0;
    any_match = 1'b0;
    free_idx = '0;
    any_free = 1'b0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (match[i]) begin
        sel = IDX_W'(i);
        any_match = 1'b1;
      end
      if (!v_q[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
    end
  end

  wire [PPN_W-1:0] hit_ppn = ppn_q[sel];
  wire [PA_W-1:0] pa_small = {hit_ppn, req_vaddr[PG_BITS-1:0]};
  wire [PA_W-1:0] pa_large = {hit_ppn[PPN_W-1:SUB_W], req_vaddr[LG_BITS-1:0]};

  wire perm_bad = req_write ? !w_q[sel] : !r_q[sel];
  wire priv_bad = req_user && k_q[sel];

  assign hit         = req_valid && any_match;
  assign miss        = req_valid && !any_match;
  assign paddr       = hit ? (l_q[sel] ? pa_large : pa_small) : '0;
  assign prot_fault  = hit && (perm_bad || priv_bad);
  assign dirty_fault = hit && req_write && !(perm_bad || priv_bad) && !d_q[sel];
  assign walk_req    = miss;
  assign walk_vpn    = miss ? vpn : '0;

  wire             take = refill_valid && !flush;
  wire [IDX_W-1:0] tgt  = any_free ? free_idx : rr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q  <= '0;
      rr_q <= '0;
    end else if (flush) begin
      v_q <= '0;
    end else if (take) begin
      v_q[tgt] <= 1'b1;
      rr_q <= (rr_q == IDX_W'(N_ENT - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      tag_q[tgt] <= refill_vpn;
      ppn_q[tgt] <= refill_ppn;
      r_q[tgt]   <= refill_rd;
      w_q[tgt]   <= refill_wr;
      d_q[tgt]   <= refill_dirty;
      k_q[tgt]   <= refill_kern;
      l_q[tgt]   <= refill_large;
    end
  end
endmodule

module tlb_prot_chk #(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int PG_BITS = 12
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    flush,
  input logic                    req_valid,
  input logic [VA_W-1:0]         req_vaddr,
  input logic [PA_W-1:0]         paddr,
  input logic                    hit,
  input logic                    miss,
  input logic                    prot_fault,
  input logic                    dirty_fault,
  input logic                    walk_req,
  input logic [VA_W-PG_BITS-1:0] walk_vpn
);
  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !hit && !miss && !walk_req && !prot_fault && !dirty_fault && paddr == '0);
  // R4
  miss_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> walk_req && !hit && !prot_fault && walk_vpn == req_vaddr[VA_W-1:PG_BITS]);
  // R7
  dirty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dirty_fault |-> hit && !prot_fault);
  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !hit);
  // R2
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit && miss));
endmodule

bind tlb_prot tlb_prot_chk #(.VA_W(VA_W), .PA_W(PA_W), .PG_BITS(PG_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid),
  .req_vaddr(req_vaddr), .paddr(paddr), .hit(hit), .miss(miss),
  .prot_fault(prot_fault), .dirty_fault(dirty_fault),
  .walk_req(walk_req), .walk_vpn(walk_vpn)
);

// File: tb/tb_tlb_prot.sv
module tb_tlb_prot;
  localparam int N = 16;

  logic clk = 0;
  always #5 clk = ~clk;

  logic        rst_n, flush, req_valid, req_write, req_user;
  logic [31:0] req_vaddr;
  logic        refill_valid, refill_rd, refill_wr, refill_dirty, refill_kern, refill_large;
  logic [19:0] refill_vpn, refill_ppn;
  logic [31:0] paddr;
  logic        hit, miss, prot_fault, dirty_fault, walk_req;
  logic [19:0] walk_vpn;

  tlb_prot dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid),
    .req_vaddr(req_vaddr), .req_write(req_write), .req_user(req_user),
    .refill_valid(refill_valid), .refill_vpn(refill_vpn), .refill_ppn(refill_ppn),
    .refill_rd(refill_rd), .refill_wr(refill_wr), .refill_dirty(refill_dirty),
    .refill_kern(refill_kern), .refill_large(refill_large),
    .paddr(paddr), .hit(hit), .miss(miss), .prot_fault(prot_fault),
    .dirty_fault(dirty_fault), .walk_req(walk_req), .walk_vpn(walk_vpn)
  );

  int vectors = 0, errors = 0;
  bit done = 0;

  bit        mv[N], mr[N], mw[N], md[N], mk[N], ml[N];
  bit [19:0] mtag[N], mppn[N];
  int        mptr;

  task automatic model_reset();
    for (int i = 0; i < N; i++) mv[i] = 0;
    mptr = 0;
  endtask

  // lookup, refill, flush in one cycle; outputs checked before the edge
  task automatic step(input bit rv, input bit [31:0] va, input bit wr, input bit us,
                      input bit fv, input bit [19:0] ftag, input bit [19:0] fppn,
                      input bit [4:0] fbits, input bit fl, input string tag);
    int idx;
    bit e_hit, e_miss, e_prot, e_dirty;
    bit [31:0] e_pa;
    bit [19:0] e_wv;
    bit [56:0] got, exp;
    @(negedge clk);
    req_valid = rv; req_vaddr = va; req_write = wr; req_user = us;
    refill_valid = fv; refill_vpn = ftag; refill_ppn = fppn;
    {refill_rd, refill_wr, refill_dirty, refill_kern, refill_large} = fbits;
    flush = fl;
    #1;
    idx = -1;
    for (int i = N - 1; i >= 0; i--)
      if (mv[i] && mtag[i][19:10] == va[31:22] && (ml[i] || mtag[i][9:0] == va[21:12])) idx = i;
    e_hit = rv && idx >= 0;
    e_miss = rv && idx < 0;
    e_pa = 0; e_prot = 0; e_dirty = 0;
    if (e_hit) begin
      e_pa = ml[idx] ? {mppn[idx][19:10], va[21:0]} : {mppn[idx], va[11:0]};
      e_prot = (wr ? !mw[idx] : !mr[idx]) || (us && mk[idx]);
      e_dirty = wr && !e_prot && !md[idx];
    end
    e_wv = e_miss ? va[31:12] : 20'h0;
    got = {hit, miss, prot_fault, dirty_fault, walk_req, walk_vpn, paddr};
    exp = {e_hit, e_miss, e_prot, e_dirty, e_miss, e_wv, e_pa};
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s va=%h got h/m/p/d/w=%b%b%b%b%b wvpn=%h pa=%h exp %b%b%b%b%b wvpn=%h pa=%h",
               tag, va, hit, miss, prot_fault, dirty_fault, walk_req, walk_vpn, paddr,
               e_hit, e_miss, e_prot, e_dirty, e_miss, e_wv, e_pa);
    end
    @(posedge clk);
    if (fl) begin
      for (int i = 0; i < N; i++) mv[i] = 0;
    end else if (fv) begin
      int t;
      t = mptr;
      for (int i = N - 1; i >= 0; i--) if (!mv[i]) t = i;
      mv[t] = 1; mtag[t] = ftag; mppn[t] = fppn;
      {mr[t], mw[t], md[t], mk[t], ml[t]} = fbits;
      mptr = (mptr + 1) % N;
    end
  endtask

  task automatic look(input bit [31:0] va, input bit wr, input bit us, input string tag);
    step(1, va, wr, us, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic fill(input bit [19:0] vpn, input bit [19:0] ppn, input bit [4:0] bits,
                      input string tag);
    step(0, 0, 0, 0, 1, vpn, ppn, bits, 0, tag);
  endtask

  // fbits order: rd, wr, dirty, kern, large
  initial begin
    bit [19:0] pool[8];
    void'($urandom(32'h5EED_0042));
    rst_n = 0; flush = 0; req_valid = 0; req_vaddr = 0; req_write = 0; req_user = 0;
    refill_valid = 0; refill_vpn = 0; refill_ppn = 0;
    {refill_rd, refill_wr, refill_dirty, refill_kern, refill_large} = 0;
    model_reset();
    repeat (3) @(posedge clk);
    rst_n = 1;

    // R1: empty after reset
    for (int i = 0; i < 3; i++) look($urandom, i[0], 0, "R1");
    // R4: idle and plain miss
    step(0, 32'hDEAD_BEEF, 0, 0, 0, 0, 0, 0, 0, "R4");
    look(32'h0BAD_F00D, 1, 1, "R4");
    // R11: lookup concurrent with refill of same page misses
    step(1, 32'h1234_5678, 0, 1, 1, 20'h12345, 20'hABCDE, 5'b11100, 0, "R11");
    look(32'h1234_5678, 0, 1, "R2");
    look(32'h1234_5FFF, 1, 1, "R2");
    // R3: large page
    fill(20'h3C000, 20'h55400, 5'b10001, "R3");
    look(32'h3C2A_BCDE, 0, 0, "R3");
    look(32'h3C3F_F001, 0, 1, "R3");
    // R5: write to read-only large page
    look(32'h3C00_0010, 1, 0, "R5");
    fill(20'h00066, 20'h00F00, 5'b01100, "R5");
    look(32'h0006_6004, 0, 0, "R5");
    // R6: kernel-only page
    fill(20'h00077, 20'h00777, 5'b11110, "R6");
    look(32'h0007_7123, 0, 1, "R6");
    look(32'h0007_7123, 1, 1, "R6");
    look(32'h0007_7123, 0, 0, "R6");
    // R7: clean page
    fill(20'h00088, 20'h00888, 5'b11000, "R7");
    look(32'h0008_8000, 1, 0, "R7");
    look(32'h0008_8000, 0, 0, "R7");
    // R12: duplicate tag, lowest index wins
    fill(20'h12345, 20'h11111, 5'b00000, "R12");
    look(32'h1234_5ABC, 0, 0, "R12");
    // R10: flush with concurrent refill
    step(0, 0, 0, 0, 1, 20'h00099, 20'h00999, 5'b11100, 1, "R10");
    look(32'h1234_5678, 0, 0, "R10");
    look(32'h0009_9000, 0, 0, "R10");
    // R8: fill all free slots
    for (int i = 0; i < N; i++) fill(20'h00100 + 20'(i), 20'h0A000 + 20'(i), 5'b11100, "R8");
    for (int i = 0; i < N; i++) look({20'h00100 + 20'(i), 12'h040}, 0, 0, "R8");
    // R9: round-robin victims (pointer not moved by the dropped refill)
    fill(20'h00200, 20'h0B000, 5'b11100, "R9");
    look(32'h0010_5000, 0, 0, "R9");
    look(32'h0020_0000, 0, 0, "R9");
    fill(20'h00201, 20'h0B001, 5'b11100, "R9");
    look(32'h0010_6000, 0, 0, "R9");
    look(32'h0010_4000, 0, 0, "R9");

    // random mix
    for (int i = 0; i < 8; i++) pool[i] = 20'($urandom);
    for (int n = 0; n < 3000; n++) begin
      bit [19:0] v, f;
      v = pool[$urandom % 8];
      if ($urandom % 4 == 0) v[9:0] = 10'($urandom);
      f = pool[$urandom % 8];
      if ($urandom % 8 == 0) f = 20'($urandom);
      step($urandom % 4 != 0, {v, 12'($urandom)}, 1'($urandom), 1'($urandom),
           $urandom % 5 == 0, f, 20'($urandom), 5'($urandom), $urandom % 97 == 0, "random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired after %0d vectors, expected completion", vectors);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule